// File: doc/BRIEF.md
# Configurable Uplink Line Encoder with Start-of-Frame

This block turns stored tag data words into the serial level that drives the load modulator on the tag-to-reader link. It runs on the field clock. Each data bit lasts one bit period, chosen from eight lengths between 2 and 64 field clocks. A two-bit selector picks the line code: plain NRZ, Manchester or bi-phase. Data leaves most significant bit first. In front of each word the encoder can place a start-of-frame. This is a programmable number of preamble bits, each sent as an encoded zero, followed by a code violation that holds the line high for two bit periods.

In addressed operation, the encoder takes one word through a valid/ready handshake. It latches the configuration at that moment, sends the frame and pulses a completion flag, then returns to idle. In public mode the encoder needs no handshake. After the power-on delay it sends a single start-of-frame, then sends the word present on the data input again and again for as long as the mode stays set. Fetching words from memory, computing the CRC and the analog modulation stage are outside the block.

Top module: `uplink_encoder`

## Requirements
- R1: After reset, `mod_out`, `word_done` and `word_ready` are low. The block then waits POR_CYCLES clocks. In addressed mode `word_ready` first reads high in the POR_CYCLES-th clock after the first clock edge with reset released.
- R2: `rate_sel` values 0 to 7 select bit periods of 2, 4, 8, 16, 32, 40, 50 and 64 field clocks.
- R3: With `code_sel` 0 (NRZ), or the spare value 3, `mod_out` equals the data bit for the whole bit period.
- R4: With `code_sel` 1 (Manchester), a 1 is high in the first half of the period and low in the second half. A 0 is the reverse.
- R5: With `code_sel` 2 (bi-phase), `mod_out` inverts at the start of every bit. A 0 adds a second inversion at mid-bit; a 1 holds its level for the whole period.
- R6: When `sof_en` is set, the word is preceded by `pre_len` preamble bits, each coded as a 0 in the selected line code, then by a violation that keeps `mod_out` high for two bit periods. With `pre_len` 0 only the violation is sent.
- R7: A word is accepted on a clock edge where `word_valid` and `word_ready` are both high. Its first output level appears on `mod_out` one clock after that edge. Bits follow most significant first, with no gap between symbols.
- R8: `word_done` is a single-clock pulse, high during the final clock of the last data bit on `mod_out`. Afterwards `mod_out` rests low and `word_ready` is high.
- R9: Rate, code, start-of-frame enable and preamble length are captured when a word is accepted. Changes to them while the word is being sent have no effect on that word.
- R10: In public mode, `word_ready` stays low and `word_done` never pulses. After the power-on delay, exactly one start-of-frame (with `pre_len` preamble bits, whatever `sof_en` is) is sent, its first level appearing one clock after `word_ready` would have risen. The `word_data` word then repeats back to back with no further start-of-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Field clock |
| rst_n | input | 1 | Synchronous reset, active low |
| public_mode | input | 1 | Cyclic broadcast mode, held static |
| rate_sel | input | 3 | Bit period selector |
| code_sel | input | 2 | Line code: 0 NRZ, 1 Manchester, 2 bi-phase, 3 NRZ |
| sof_en | input | 1 | Send a start-of-frame before an addressed word |
| pre_len | input | PRE_W | Number of preamble bits |
| word_valid | input | 1 | A word is offered |
| word_data | input | WORD_W | Word to send, MSB first |
| word_ready | output | 1 | Encoder idle and able to accept a word |
| mod_out | output | 1 | Modulation control level |
| word_done | output | 1 | Pulse on the final clock of a word |

## Verification
The checker watches several properties on every clock:
- the violation stays high for its whole duration;
- a Manchester bit flips at its midpoint;
- a bi-phase bit flips at its start;
- the completion pulse lasts one clock and never appears in public mode;
- `word_ready` drops after an accepted word;
- the line rests low while idle.

Other behaviour only the bench scenarios can show. These cover the exact length of each bit period for every rate, the preamble count, most-significant-first ordering, and the level sequence across symbol boundaries. They also cover the isolation of a running word from configuration changes and the single start-of-frame before the endless public stream.

// File: rtl/uplink_pkg.sv
// Package: shared types and the bit-period table for the uplink encoder.
// Assumes all bit periods are even, so a half period is exact.
package uplink_pkg;
    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        CODE_NRZ = 2'd0,
        CODE_MAN = 2'd1,
        CODE_BIP = 2'd2,
        CODE_SPR = 2'd3
    } line_code_e;

    typedef enum logic [2:0] {
        PH_POR  = 3'd0,
        PH_IDLE = 3'd1,
        PH_PRE  = 3'd2,
        PH_VIOL = 3'd3,
        PH_DATA = 3'd4
    } phase_e;

    // Map the 3-bit rate selector onto a bit period in field clocks.
    function automatic logic [CNT_W-1:0] period_of(input logic [2:0] sel);
        case (sel)
            3'd0:    return CNT_W'(2);
            3'd1:    return CNT_W'(4);
            3'd2:    return CNT_W'(8);
            3'd3:    return CNT_W'(16);
            3'd4:    return CNT_W'(32);
            3'd5:    return CNT_W'(40);
            3'd6:    return CNT_W'(50);
            default: return CNT_W'(64);
        endcase
    endfunction
endpackage

// File: rtl/uplink_timer.sv
// Module: symbol timer. Counts field clocks inside the current symbol.
// A data or preamble symbol lasts one bit period; a violation lasts two.
// Assumes the period input stays constant while a symbol runs.
module uplink_timer
    import uplink_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             long_sym,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             sym_end,
    output logic             at_start,
    output logic             at_mid,
    output logic             first_half
);
    logic [CNT_W-1:0] len_m1;
    logic [CNT_W-1:0] half;

    // Derive the last count of the symbol and the mid-bit point.
    always_comb begin
        half       = period >> 1;
        len_m1     = long_sym ? CNT_W'((period << 1) - 1'b1) : CNT_W'(period - 1'b1);
        sym_end    = running && (cnt == len_m1);
        at_start   = (cnt == '0);
        at_mid     = (cnt == half);
        first_half = (cnt < half);
    end

    // Advance the count; clear it at each symbol end and while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !running || sym_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uplink_coder.sv
// Module: line coder. Forms the modulation level for the current clock
// from the phase, the bit and the line code, and registers it on mod_out.
// Bi-phase uses the registered level as the previous line state.
module uplink_coder
    import uplink_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  phase_e     phase,
    input  logic       bit_in,
    input  line_code_e code,
    input  logic       at_start,
    input  logic       at_mid,
    input  logic       first_half,
    output logic       mod_out
);
    logic bval;
    logic level;

    // Select the level for this clock according to phase and line code.
    always_comb begin
        bval  = (phase == PH_DATA) ? bit_in : 1'b0;
        level = 1'b0;
        if (phase == PH_VIOL) begin
            level = 1'b1;
        end else if (phase == PH_PRE || phase == PH_DATA) begin
            case (code)
                CODE_MAN: level = first_half ? bval : ~bval;
                CODE_BIP: level = (at_start || (at_mid && !bval)) ? ~mod_out : mod_out;
                default:  level = bval;
            endcase
        end
    end

    // Register the level so the output is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_out <= 1'b0;
        end else begin
            mod_out <= level;
        end
    end
endmodule

// File: rtl/uplink_seq.sv
// Module: frame sequencer. Runs the power-on delay, accepts words,
// steps through preamble, violation and data bits, and handles public mode.
// Assumes public_mode is a static strap; config is captured per word.
module uplink_seq
    import uplink_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int PRE_W      = 4,
    parameter int POR_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             public_mode,
    input  logic [2:0]       rate_sel,
    input  logic [1:0]       code_sel,
    input  logic             sof_en,
    input  logic [PRE_W-1:0] pre_len,
    input  logic             word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic             sym_end,
    output phase_e           phase,
    output logic             cur_bit,
    output logic [CNT_W-1:0] period,
    output line_code_e       code,
    output logic             word_ready,
    output logic             word_done
);
    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int POR_W = $clog2(POR_CYCLES + 1);

    logic [POR_W-1:0]  por_q;
    logic [PRE_W-1:0]  pre_idx;
    logic [PRE_W-1:0]  cfg_pre;
    logic [IDX_W-1:0]  bit_idx;
    logic [WORD_W-1:0] shreg;
    logic [2:0]        cfg_rate;
    logic              last_bit;
    logic              load_now;
    phase_e            start_ph;

    // Decide when a word is taken in and which phase a new frame begins in.
    always_comb begin
        last_bit = (bit_idx == IDX_W'(WORD_W - 1));
        load_now = (phase == PH_IDLE && (public_mode || word_valid))
                || (phase == PH_POR && por_q == '0 && public_mode)
                || (phase == PH_DATA && sym_end && last_bit && public_mode);
        if (public_mode || sof_en) begin
            start_ph = (pre_len != '0) ? PH_PRE : PH_VIOL;
        end else begin
            start_ph = PH_DATA;
        end
        word_ready = (phase == PH_IDLE) && !public_mode;
        cur_bit    = shreg[WORD_W-1];
        period     = period_of(cfg_rate);
    end

    // Phase control, preamble and bit counters, completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_POR;
            por_q     <= POR_W'(POR_CYCLES - 1);
            pre_idx   <= '0;
            bit_idx   <= '0;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            case (phase)
                PH_POR: begin
                    if (por_q == '0) begin
                        phase   <= public_mode ? start_ph : PH_IDLE;
                        pre_idx <= '0;
                        bit_idx <= '0;
                    end else begin
                        por_q <= por_q - 1'b1;
                    end
                end
                PH_IDLE: begin
                    if (load_now) begin
                        phase   <= start_ph;
                        pre_idx <= '0;
                        bit_idx <= '0;
                    end
                end
                PH_PRE: begin
                    if (sym_end) begin
                        if (pre_idx == PRE_W'(cfg_pre - 1'b1)) phase <= PH_VIOL;
                        pre_idx <= pre_idx + 1'b1;
                    end
                end
                PH_VIOL: begin
                    if (sym_end) begin
                        phase   <= PH_DATA;
                        bit_idx <= '0;
                    end
                end
                PH_DATA: begin
                    if (sym_end) begin
                        if (last_bit) begin
                            bit_idx <= '0;
                            if (!public_mode) begin
                                phase     <= PH_IDLE;
                                word_done <= 1'b1;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Word shift register and per-word configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            cfg_rate <= '0;
            code     <= CODE_NRZ;
            cfg_pre  <= '0;
        end else if (load_now) begin
            shreg    <= word_data;
            cfg_rate <= rate_sel;
            code     <= line_code_e'(code_sel);
            cfg_pre  <= pre_len;
        end else if (phase == PH_DATA && sym_end) begin
            shreg <= shreg << 1;
        end
    end
endmodule

// File: rtl/uplink_encoder.sv
// Module: uplink encoder top. Connects sequencer, symbol timer and line coder.
// Assumes clk is the recovered field clock and rst_n is synchronous.
module uplink_encoder
    import uplink_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int PRE_W      = 4,
    parameter int POR_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              public_mode,
    input  logic [2:0]        rate_sel,
    input  logic [1:0]        code_sel,
    input  logic              sof_en,
    input  logic [PRE_W-1:0]  pre_len,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              mod_out,
    output logic              word_done
);
    phase_e           seq_phase;
    line_code_e       seq_code;
    logic             seq_bit;
    logic [CNT_W-1:0] seq_period;
    logic [CNT_W-1:0] tmr_cnt;
    logic [CNT_W-1:0] tmr_half;
    logic             tmr_end;
    logic             tmr_start;
    logic             tmr_mid;
    logic             tmr_first;
    logic             sym_run;

    // Timer runs only while a symbol is on the line.
    always_comb begin
        sym_run  = (seq_phase == PH_PRE) || (seq_phase == PH_VIOL) || (seq_phase == PH_DATA);
        tmr_half = seq_period >> 1;
    end

    uplink_seq #(
        .WORD_W     (WORD_W),
        .PRE_W      (PRE_W),
        .POR_CYCLES (POR_CYCLES)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .public_mode (public_mode),
        .rate_sel    (rate_sel),
        .code_sel    (code_sel),
        .sof_en      (sof_en),
        .pre_len     (pre_len),
        .word_valid  (word_valid),
        .word_data   (word_data),
        .sym_end     (tmr_end),
        .phase       (seq_phase),
        .cur_bit     (seq_bit),
        .period      (seq_period),
        .code        (seq_code),
        .word_ready  (word_ready),
        .word_done   (word_done)
    );

    uplink_timer tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (sym_run),
        .long_sym   (seq_phase == PH_VIOL),
        .period     (seq_period),
        .cnt        (tmr_cnt),
        .sym_end    (tmr_end),
        .at_start   (tmr_start),
        .at_mid     (tmr_mid),
        .first_half (tmr_first)
    );

    uplink_coder cod_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (seq_phase),
        .bit_in     (seq_bit),
        .code       (seq_code),
        .at_start   (tmr_start),
        .at_mid     (tmr_mid),
        .first_half (tmr_first),
        .mod_out    (mod_out)
    );
endmodule

// File: rtl/uplink_encoder_chk.sv
// Module: property checker for the uplink encoder, attached with bind.
// Observes ports plus the phase, code and symbol count of the top.
module uplink_encoder_chk
    import uplink_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             public_mode,
    input logic             word_valid,
    input logic             word_ready,
    input logic             word_done,
    input logic             mod_out,
    input phase_e           phase,
    input line_code_e       code,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] half
);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && $past(phase) == PH_IDLE) |-> !mod_out);

    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready) |=> !word_ready);

    p_public_nodone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (public_mode && $past(public_mode)) |-> !word_done);

    p_viol_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_VIOL && $past(phase) == PH_VIOL) |-> mod_out);

    p_man_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && code == CODE_MAN && cnt == half) |=> (mod_out != $past(mod_out)));

    p_bip_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && code == CODE_BIP && cnt == '0) |=> (mod_out != $past(mod_out)));
endmodule

bind uplink_encoder uplink_encoder_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .public_mode (public_mode),
    .word_valid  (word_valid),
    .word_ready  (word_ready),
    .word_done   (word_done),
    .mod_out     (mod_out),
    .phase       (seq_phase),
    .code        (seq_code),
    .cnt         (tmr_cnt),
    .half        (tmr_half)
);

// File: tb/uplink_encoder_tb_top.sv
// Scoreboard bench: the driver queues the expected level of every clock,
// the monitor pops and compares once the word is accepted.
module uplink_encoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 32;
    localparam int PRE_W      = 4;
    localparam int POR_CYCLES = 16;

    typedef struct {
        logic lvl;
        logic done;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              public_mode = 1'b0;
    logic [2:0]        rate_sel = '0;
    logic [1:0]        code_sel = '0;
    logic              sof_en = 1'b0;
    logic [PRE_W-1:0]  pre_len = '0;
    logic              word_valid = 1'b0;
    logic [WORD_W-1:0] word_data = '0;
    logic              word_ready;
    logic              mod_out;
    logic              word_done;

    exp_t  q[$];
    logic  mprev;
    string cur_req = "R7";
    int    nchk = 0;
    int    nerr = 0;
    logic  samp[600];

    uplink_encoder #(
        .WORD_W     (WORD_W),
        .PRE_W      (PRE_W),
        .POR_CYCLES (POR_CYCLES)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .public_mode (public_mode),
        .rate_sel    (rate_sel),
        .code_sel    (code_sel),
        .sof_en      (sof_en),
        .pre_len     (pre_len),
        .word_valid  (word_valid),
        .word_data   (word_data),
        .word_ready  (word_ready),
        .mod_out     (mod_out),
        .word_done   (word_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R2: bit period table
    function automatic int period_tb(input logic [2:0] sel);
        case (sel)
            3'd0: return 2;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 16;
            3'd4: return 32;
            3'd5: return 40;
            3'd6: return 50;
            default: return 64;
        endcase
    endfunction

    // Push the per-clock levels of one symbol, from the line code rules.
    task automatic push_sym(input int len, input int p, input logic b, input logic [1:0] code,
                            input logic viol, input logic last_done);
        for (int c = 0; c < len; c++) begin
            logic lv;
            if (viol) lv = 1'b1;
            else if (code == 2'd1) lv = (c < p / 2) ? b : ~b;
            else if (code == 2'd2) lv = (c == 0 || (c == p / 2 && !b)) ? ~mprev : mprev;
            else lv = b;
            mprev = lv;
            q.push_back('{lv, last_done && (c == len - 1)});
        end
    endtask

    task automatic build(input logic [WORD_W-1:0] d, input int p, input logic [1:0] code,
                         input logic sof, input int pre, input int nwords, input logic with_done);
        mprev = 1'b0;
        if (sof) begin
            for (int k = 0; k < pre; k++) push_sym(p, p, 1'b0, code, 1'b0, 1'b0);
            push_sym(2 * p, p, 1'b0, code, 1'b1, 1'b0);
        end
        for (int w = 0; w < nwords; w++) begin
            for (int i = WORD_W - 1; i >= 0; i--) begin
                push_sym(p, p, d[i], code, 1'b0, with_done && (i == 0));
            end
        end
    endtask

    // Driver: queue expected levels, offer the word, optionally disturb config.
    task automatic send_word(input string req, input logic [WORD_W-1:0] d, input logic [2:0] rate,
                             input logic [1:0] code, input logic sof, input int pre,
                             input logic disturb);
        @(posedge clk);
        #1;
        cur_req    = req;
        rate_sel   = rate;
        code_sel   = code;
        sof_en     = sof;
        pre_len    = PRE_W'(pre);
        word_data  = d;
        build(d, period_tb(rate), code, sof, pre, 1, 1'b1);
        word_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (word_ready) break;
        end
        @(posedge clk);
        #1;
        word_valid = 1'b0;
        if (disturb) begin
            // R9: change every config input while the word is running
            rate_sel  = ~rate;
            code_sel  = ~code;
            sof_en    = ~sof;
            pre_len   = ~PRE_W'(pre);
            word_data = ~d;
        end
        while (q.size() != 0) @(negedge clk);
        chk(word_ready == 1'b1, "R8 ready after word", int'(word_ready), 1);
        @(negedge clk);
        chk(mod_out == 1'b0, "R8 idle level", int'(mod_out), 0);
        chk(word_done == 1'b0, "R8 done single clock", int'(word_done), 0);
    endtask

    // Monitor: on a handshake, compare each following clock with the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (word_valid && word_ready && !public_mode) begin
                int n;
                n = q.size();
                @(posedge clk);
                @(posedge clk);
                for (int i = 0; i < n; i++) begin
                    exp_t e;
                    @(negedge clk);
                    e = q.pop_front();
                    chk(mod_out == e.lvl, cur_req, int'(mod_out), int'(e.lvl));
                    chk(word_done == e.done, "R8 done timing", int'(word_done), int'(e.done));
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        nerr++;
        nchk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int f;
        int start;
        // R1: reset state and power-on delay in addressed mode
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int j = 0; j <= POR_CYCLES; j++) begin
            @(negedge clk);
            if (j == 0) begin
                chk(mod_out == 1'b0, "R1 mod_out low", int'(mod_out), 0);
                chk(word_done == 1'b0, "R1 done low", int'(word_done), 0);
            end
            chk(word_ready == (j == POR_CYCLES), "R1 ready after delay", int'(word_ready),
                int'(j == POR_CYCLES));
        end

        send_word("R3 NRZ P2", 32'hA5C3_0F69, 3'd0, 2'd0, 1'b0, 0, 1'b0);
        send_word("R4 R6 Manchester P8 pre3", 32'h8000_0001, 3'd2, 2'd1, 1'b1, 3, 1'b0);
        send_word("R5 R6 biphase P4 pre2", 32'hF0F0_1234, 3'd1, 2'd2, 1'b1, 2, 1'b0);
        send_word("R5 R2 biphase P40", 32'h0000_FFFF, 3'd5, 2'd2, 1'b0, 0, 1'b0);
        send_word("R6 R2 NRZ P50 violation only", 32'h1357_9BDF, 3'd6, 2'd0, 1'b1, 0, 1'b0);
        send_word("R9 R2 Manchester P64 config disturbed", 32'hDEAD_BEEF, 3'd7, 2'd1, 1'b0, 0, 1'b1);
        send_word("R3 spare code P16", 32'h6B2C_91E4, 3'd3, 2'd3, 1'b0, 0, 1'b0);
        send_word("R2 R6 Manchester P32 pre5", 32'h2468_ACE1, 3'd4, 2'd1, 1'b1, 5, 1'b0);

        // R10: public mode, one start-of-frame then cyclic data
        @(posedge clk);
        #1;
        rst_n       = 1'b0;
        public_mode = 1'b1;
        rate_sel    = 3'd1;
        code_sel    = 2'd1;
        sof_en      = 1'b0;
        pre_len     = PRE_W'(2);
        word_data   = 32'hC3A5_0F96;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int j = 0; j < 600; j++) begin
            @(negedge clk);
            samp[j] = mod_out;
            if (word_ready || word_done) begin
                chk(1'b0, "R10 ready/done stay low", int'({word_ready, word_done}), 0);
            end
        end
        chk(1'b1, "R10 ready/done stay low", 0, 0);
        f = -1;
        for (int j = 0; j < 600; j++) begin
            if (f < 0 && samp[j]) f = j;
        end
        start = f - period_tb(3'd1) / 2;
        chk(start == POR_CYCLES + 1, "R10 R1 public start time", start, POR_CYCLES + 1);
        q.delete();
        build(32'hC3A5_0F96, period_tb(3'd1), 2'd1, 1'b1, 2, 3, 1'b0);
        for (int i = 0; i < 400; i++) begin
            exp_t e;
            e = q.pop_front();
            if (start >= 0 && start + i < 600) begin
                if (samp[start + i] != e.lvl) begin
                    chk(1'b0, "R10 public stream", int'(samp[start + i]), int'(e.lvl));
                end
            end
        end
        chk(1'b1, "R10 public stream", 0, 0);
        q.delete();

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule